// File: doc/BRIEF.md
# Third-Order Delta-Sigma Decimation Filter

This block turns the one-bit stream of an external bipolar delta-sigma modulator into signed 16-bit words at a much lower rate. Each modulator bit enters as a signed step of plus one or minus one and passes through a chain of three integrators that run on every modulator clock. A control counter picks one clock in every 512. On that clock the last integrator value goes through three differentiator stages. The wide result is then cut down to 16 bits and presented with a one-cycle valid strobe. With a 10 MHz modulator clock, a new word arrives at roughly 19.5 kHz.

A polarity input can swap the meaning of the modulator bit, so that a modulator whose output sense is inverted still gives words of the correct sign. Two reset inputs split the state. An active-low datapath reset clears the integrators, the differentiators and the decimation counter. An active-high register reset clears only the output word and its strobe. Several identical instances are expected to sit side by side, one per measurement channel. Each instance is clocked by its own modulator clock.

Top module: `sinc3_decim`

## Requirements
- R1: With `invertPolarity` low, a modulator bit of 1 counts as +1 and a bit of 0 counts as -1. A constant stream of ones settles to 16'h7FFF and a constant stream of zeros settles to 16'h8000.
- R2: With `invertPolarity` high, a bit of 1 counts as -1 and a bit of 0 counts as +1. A constant stream of ones therefore settles to 16'h8000.
- R3: For a periodic input whose period P divides 512 and that holds K ones per period, the word settles to 32768*(2K-P)/P. Examples are 0 for alternating bits, 16384 for three ones in four and -16384 for one one in four. Every word produced four or more decimation periods after a pattern change reflects only the new pattern.
- R4: The word is the full 29-bit filter result shifted right arithmetically by 12 bits. A result of +32768 is clamped to +32767, and values below that are passed unchanged (seven ones in eight gives 24576, fifteen in sixteen gives 28672).
- R5: `sampleValid` is high for exactly one clock cycle per word. Successive pulses are 512 clock cycles apart.
- R6: `sampleOut` changes only on a cycle in which `sampleValid` is high, or as a result of the register reset.
- R7: The first `sampleValid` pulse after release of `rstDpN` becomes visible after the 513th rising edge at which `rstDpN` is sampled high.
- R8: While `rstDpN` is low, no `sampleValid` pulse is produced and `sampleOut` keeps its last value.
- R9: A rising edge with `rstRegs` high clears `sampleOut` to 0 and `sampleValid` to 0 without disturbing the datapath. The next pulse keeps the 512-cycle spacing and carries the correct filtered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock; all state changes on its rising edge |
| rstDpN | input | 1 | Synchronous active-low reset of integrators, differentiators and decimation counter |
| rstRegs | input | 1 | Synchronous active-high reset of the output word and strobe |
| invertPolarity | input | 1 | High swaps the signed meaning of the modulator bit |
| modBit | input | 1 | Modulator output bit, sampled every clock |
| sampleOut | output | 16 | Signed filtered word, two's complement |
| sampleValid | output | 1 | One-cycle strobe marking a new `sampleOut` |

## Verification
The bench builds the block with its default parameters: third order, a decimation factor of 512 and a 16-bit word. With these values the full-scale input lands exactly on the clamp boundary of R4. Periodic patterns whose period divides 512 then give exact, closed-form settled words, so the bench can predict every checked value from the pattern's duty alone. The same parameters keep each pattern's settling time near 2,500 cycles. That leaves room to run ten patterns, both polarities and both reset paths, including the 513-cycle restart latency.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  // Strobes from the decimation control to the filter datapath.
  typedef struct packed {
    logic combEn;   // one cycle per decimation period: advance differentiators
    logic outLoad;  // one cycle later: trim and register the new word
  } sinc_ctrl_t;

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int DECIM_LOG2 = 9
) (
  input  logic       clk,
  input  logic       rstDpN,
  output sinc_ctrl_t ctrl
);

  localparam logic [DECIM_LOG2-1:0] LAST_PHASE = {DECIM_LOG2{1'b1}};

  logic [DECIM_LOG2-1:0] phaseCnt;
  logic                  loadQ;
  logic                  lastPhase;

  assign lastPhase = (phaseCnt == LAST_PHASE);

  always_ff @(posedge clk) begin
    if (!rstDpN) begin
      phaseCnt <= '0;
      loadQ    <= 1'b0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
      loadQ    <= lastPhase;
    end
  end

  // A datapath reset suppresses both strobes, including a pending load.
  assign ctrl.combEn  = rstDpN & lastPhase;
  assign ctrl.outLoad = rstDpN & loadQ;

endmodule

// File: rtl/sinc3_datapath.sv
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int ORDER      = 3,
  parameter int DECIM_LOG2 = 9,
  parameter int OUT_W      = 16
) (
  input  logic             clk,
  input  logic             rstDpN,
  input  logic             rstRegs,
  input  logic             invertPolarity,
  input  logic             modBit,
  input  sinc_ctrl_t       ctrl,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid
);

  // A +/-1 input needs two signed bits; each stage grows by log2 of the ratio.
  localparam int ACC_W = 2 + ORDER * DECIM_LOG2;
  localparam int SHIFT = ACC_W - 1 - OUT_W;

  localparam logic signed [ACC_W-1:0] STEP_POS = {{(ACC_W-1){1'b0}}, 1'b1};
  localparam logic signed [ACC_W-1:0] STEP_NEG = {ACC_W{1'b1}};
  localparam logic signed [ACC_W-1:0] POS_MAX  =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_MIN  =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] stepVal;
  logic signed [ACC_W-1:0] integLast;
  logic signed [ACC_W-1:0] combLast;
  logic signed [ACC_W-1:0] combRes;
  logic signed [ACC_W-1:0] scaled;
  logic        [OUT_W-1:0] trimmed;

  assign stepVal = (modBit ^ invertPolarity) ? STEP_POS : STEP_NEG;

  // Integrator chain at the modulator rate, wrap-around arithmetic.
  genvar gi;
  generate
    for (gi = 0; gi < ORDER; gi++) begin : g_integ
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W-1:0] feed;
      if (gi == 0) begin : g_first
        assign feed = stepVal;
      end else begin : g_next
        assign feed = g_integ[gi-1].acc;
      end
      always_ff @(posedge clk) begin
        if (!rstDpN) acc <= '0;
        else         acc <= acc + feed;
      end
    end
  endgenerate

  assign integLast = g_integ[ORDER-1].acc;

  // Differentiator chain, advanced once per decimation period.
  genvar gc;
  generate
    for (gc = 0; gc < ORDER; gc++) begin : g_comb
      logic signed [ACC_W-1:0] cin;
      logic signed [ACC_W-1:0] dly;
      logic signed [ACC_W-1:0] diff;
      if (gc == 0) begin : g_first
        assign cin = integLast;
      end else begin : g_next
        assign cin = g_comb[gc-1].diff;
      end
      assign diff = cin - dly;
      always_ff @(posedge clk) begin
        if (!rstDpN)          dly <= '0;
        else if (ctrl.combEn) dly <= cin;
      end
    end
  endgenerate

  assign combLast = g_comb[ORDER-1].diff;

  always_ff @(posedge clk) begin
    if (!rstDpN)          combRes <= '0;
    else if (ctrl.combEn) combRes <= combLast;
  end

  // Drop the low bits, then clamp the single overflowing code.
  assign scaled = combRes >>> SHIFT;

  always_comb begin
    if (scaled > POS_MAX)      trimmed = POS_MAX[OUT_W-1:0];
    else if (scaled < NEG_MIN) trimmed = NEG_MIN[OUT_W-1:0];
    else                       trimmed = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rstRegs) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= ctrl.outLoad;
      if (ctrl.outLoad) sampleOut <= trimmed;
    end
  end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int ORDER      = 3,
  parameter int DECIM_LOG2 = 9,
  parameter int OUT_W      = 16
) (
  input  logic             clk,
  input  logic             rstDpN,
  input  logic             rstRegs,
  input  logic             invertPolarity,
  input  logic             modBit,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid
);

  sinc_ctrl_t ctrl;

  sinc3_ctrl #(
    .DECIM_LOG2(DECIM_LOG2)
  ) u_ctrl (
    .clk   (clk),
    .rstDpN(rstDpN),
    .ctrl  (ctrl)
  );

  sinc3_datapath #(
    .ORDER     (ORDER),
    .DECIM_LOG2(DECIM_LOG2),
    .OUT_W     (OUT_W)
  ) u_dp (
    .clk           (clk),
    .rstDpN        (rstDpN),
    .rstRegs       (rstRegs),
    .invertPolarity(invertPolarity),
    .modBit        (modBit),
    .ctrl          (ctrl),
    .sampleOut     (sampleOut),
    .sampleValid   (sampleValid)
  );

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int DECIM_LOG2 = 9,
  parameter int OUT_W      = 16
) (
  input logic             clk,
  input logic             rstDpN,
  input logic             rstRegs,
  input logic             invertPolarity,
  input logic             modBit,
  input logic [OUT_W-1:0] sampleOut,
  input logic             sampleValid
);

  localparam int RATIO = 1 << DECIM_LOG2;

  logic regsQ;
  int   gapCnt;
  logic seenPulse;

  always_ff @(posedge clk) regsQ <= rstRegs;

  // Cycle counter for the pulse spacing window.
  always_ff @(posedge clk) begin
    if (!rstDpN || rstRegs) begin
      gapCnt    <= 0;
      seenPulse <= 1'b0;
    end else if (sampleValid) begin
      gapCnt    <= 1;
      seenPulse <= 1'b1;
    end else begin
      gapCnt    <= gapCnt + 1;
    end
  end

  // R5: strobe lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rstRegs || !rstDpN)
    sampleValid |=> !sampleValid);

  // R5: strobes are one decimation period apart
  a_r5_spacing: assert property (@(posedge clk) disable iff (rstRegs || !rstDpN)
    (sampleValid && seenPulse) |-> (gapCnt == RATIO));

  // R6: the word moves only together with the strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (rstRegs || regsQ)
    !$stable(sampleOut) |-> sampleValid);

  // R8: a datapath reset freezes the output and suppresses strobes
  a_r8_dp_hold: assert property (@(posedge clk) disable iff (rstRegs)
    !rstDpN |=> ($stable(sampleOut) && !sampleValid));

  // R9: register reset clears the word and the strobe
  a_r9_regs_clear: assert property (@(posedge clk) disable iff (!rstDpN)
    rstRegs |=> (sampleOut == '0 && !sampleValid));

  // Polarity and bit inputs are not constrained by any property here.
  logic unusedIn;
  assign unusedIn = invertPolarity ^ modBit;

endmodule

bind sinc3_decim sinc3_decim_chk #(
  .DECIM_LOG2(DECIM_LOG2),
  .OUT_W     (OUT_W)
) u_chk (.*);

// File: tb/sinc3_decim_bench.sv
`timescale 1ns/1ps
module sinc3_decim_bench;

  localparam int NVEC = 10;
  // Pattern period, ones per period, polarity, settled signed word.
  localparam int VP   [NVEC] = '{1, 1, 2, 4, 4, 8, 1, 4, 16, 8};
  localparam int VK   [NVEC] = '{1, 0, 1, 3, 1, 7, 1, 3, 15, 1};
  localparam int VI   [NVEC] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 1};
  localparam int VEXP [NVEC] = '{32767, -32768, 0, 16384, -16384, 24576,
                                 -32768, -16384, 28672, 24576};

  logic        clk = 1'b0;
  logic        rstDpN = 1'b0;
  logic        rstRegs = 1'b1;
  logic        invertPolarity = 1'b0;
  logic        modBit = 1'b0;
  logic [15:0] sampleOut;
  logic        sampleValid;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;
  int lastValidTick = 0;
  int gapLast = 0;
  int stabErr = 0;
  int pulseErr = 0;
  int patP = 1;
  int patK = 0;
  logic [15:0] prevOut = '0;
  logic        prevValid = 1'b0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  sinc3_decim u_sinc3_decim (
    .clk           (clk),
    .rstDpN        (rstDpN),
    .rstRegs       (rstRegs),
    .invertPolarity(invertPolarity),
    .modBit        (modBit),
    .sampleOut     (sampleOut),
    .sampleValid   (sampleValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: observe after the rising edge, then drive the next bit.
  task automatic tick();
    @(negedge clk);
    tickCnt++;
    if (sampleValid) begin
      gapLast = tickCnt - lastValidTick;
      lastValidTick = tickCnt;
      if (prevValid) pulseErr++;
    end
    if (!sampleValid && !rstRegs && sampleOut !== prevOut) stabErr++;
    prevOut   = sampleOut;
    prevValid = sampleValid;
    modBit    = ((tickCnt % patP) < patK);
  endtask

  task automatic waitValid(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!sampleValid && n < 5000);
  endtask

  initial begin
    int n;
    logic [15:0] held;
    bit sawValid;

    repeat (4) tick();
    // R9: reset state
    check(sampleOut == 16'h0 && !sampleValid, "R9 reset state", sampleOut, 0);

    rstDpN  = 1'b1;
    rstRegs = 1'b0;
    waitValid(n);
    check(n == 513, "R7 first strobe latency", n, 513);

    // Vector table: R1 R2 R3 R4 settled words
    for (int v = 0; v < NVEC; v++) begin
      patP = VP[v];
      patK = VK[v];
      invertPolarity = VI[v][0];
      for (int w = 0; w < 5; w++) waitValid(n);
      check($signed(sampleOut) == VEXP[v], "R1/R2/R3/R4 settled word",
            $signed(sampleOut), VEXP[v]);
      check(gapLast == 512, "R5 strobe spacing", gapLast, 512);
    end
    check(pulseErr == 0, "R5 single-cycle strobe", pulseErr, 0);

    // R9: register reset mid-period leaves datapath running
    repeat (100) tick();
    rstRegs = 1'b1;
    tick();
    check(sampleOut == 16'h0 && !sampleValid, "R9 register reset clears",
          sampleOut, 0);
    rstRegs = 1'b0;
    waitValid(n);
    check(gapLast == 512, "R9 cadence kept", gapLast, 512);
    check($signed(sampleOut) == 24576, "R9 value kept", $signed(sampleOut), 24576);

    // R8: datapath reset holds output, no strobes
    repeat (50) tick();
    held = sampleOut;
    rstDpN = 1'b0;
    sawValid = 0;
    repeat (600) begin
      tick();
      if (sampleValid) sawValid = 1;
    end
    check(!sawValid, "R8 no strobe in datapath reset", sawValid, 0);
    check(sampleOut == held, "R8 output held", sampleOut, held);
    rstDpN = 1'b1;
    waitValid(n);
    check(n == 513, "R7 restart latency", n, 513);

    check(stabErr == 0, "R6 output stable between strobes", stabErr, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule